// File: doc/BRIEF.md
# Daisy-Chain Serial Configuration Receiver

This block is the load front end of a programmable device that takes its configuration as one serial stream shared by a chain of devices. An external configuration clock drives it. On each rising edge it samples one bit from the serial input, and it does so only while the 3-bit mode input selects serial-slave operation (3'b111) and the shared INIT line reads high. It looks for a header made of a run of ones, a 4-bit start pattern, a 24-bit length and four fill bits. It then keeps the next `OWN_BITS` bits for itself and delivers them as 32-bit parallel words, each with a one-cycle strobe. It passes the header, and every bit that arrives after its own share, to a serial output for the next device in the chain.

The serial output is re-timed on the falling clock edge, so each forwarded bit appears half a period after it was sampled. The next device can then capture it on the following rising edge. A sticky DONE flag rises when the number of bits received after the fill field reaches the length carried in the header. Forwarding carries on after DONE.

Top module: `cfg_serial_rx`

## Requirements
- R1: A bit is taken from `din` on the rising edge of `cfgClk` only while `modeSel` is 3'b111 and `initLine` is high. At any other time the bit is ignored and no internal state changes: no word strobe occurs, and a header is still needed afterwards.
- R2: `dout` changes only after the falling edge of `cfgClk`. It then carries the forwarded value of the bit sampled at the rising edge half a period earlier, and keeps its previous value between that rising edge and the falling edge.
- R3: `dout` is high while `modeSel` is not 3'b111, while `initLine` is low, and while the block is hunting for a header and has not yet seen at least eight consecutive 1 bits.
- R4: A header is accepted only after at least eight consecutive 1 bits followed by the start pattern 0,0,1,0 in arrival order. A shorter run of ones, or a pattern that does not match, sends the block back to hunting. A mismatching 1 counts as the first bit of a new run.
- R5: Once the run of ones has reached eight, the header bits (start pattern, length and fill) are repeated on `dout` bit for bit.
- R6: The 24 bits after the start pattern are the length, sent most significant bit first. The four bits after the length are fill bits, whatever their value.
- R7: The next `OWN_BITS` bits after the fill belong to this device, and `dout` stays high while they arrive. Each group of 32 is presented on `wordData`, with its first-received bit at bit 31. `wordStrobe` is high for exactly one cycle, following the rising edge that sampled the 32nd bit.
- R8: Every bit after the device's own share is forwarded to `dout`.
- R9: A count starts at the first own bit and covers both own and forwarded bits. `doneFlag` rises after the rising edge whose bit brings that count to the header length. It then stays high until reset, and forwarding continues. A length of zero never raises it.
- R10: An active-low asynchronous `rstN` drives `dout` high and clears `doneFlag`, `wordStrobe`, the counters and the header search, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfgClk | input | 1 | Externally driven configuration clock |
| rstN | input | 1 | Asynchronous reset, active low |
| din | input | 1 | Serial configuration data in |
| modeSel | input | 3 | Mode selection; 3'b111 selects serial slave |
| initLine | input | 1 | Shared init status; high when every chained device is cleared |
| dout | output | 1 | Serial data out to the next device, updated on falling edges |
| wordData | output | 32 | Last completed 32-bit word of this device's share |
| wordStrobe | output | 1 | One-cycle pulse marking a new word on `wordData` |
| doneFlag | output | 1 | Sticky flag: bit count has reached the header length |

## Verification
The word strobe and the rise of DONE can land on the same rising edge. This happens when the header length equals a multiple of 32 that falls within the device's own share. With a length of 32 the first word completes together with DONE. With a length of 64 the last own word completes together with DONE and with the hand-over to forwarding. The bench drives both lengths. On the cycle after that edge it expects the strobe, the right word and DONE together, and then checks that the next bits appear on the serial output.

// File: rtl/cfg_serial_rx_pkg.sv
package cfg_serial_rx_pkg;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_SYNC,
    ST_LEN,
    ST_FILL,
    ST_LOAD,
    ST_PASS
  } rxState_t;

  // Strobes from the control FSM to the datapath, valid for the current bit.
  typedef struct packed {
    logic fwdBit;     // value to send downstream for this bit
    logic shiftLen;   // bit belongs to the length field
    logic shiftWord;  // bit belongs to this device's share
    logic wordLast;   // bit completes a parallel word
    logic countBit;   // bit counts towards the length total
  } rxCtrl_t;

  // Start pattern, bit 3 arrives first.
  localparam logic [3:0] SyncPattern = 4'b0010;

endpackage

// File: rtl/cfg_rx_ctrl.sv
module cfg_rx_ctrl
  import cfg_serial_rx_pkg::*;
#(
  parameter int OWN_BITS  = 64,
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 24,
  parameter int MIN_ONES  = 8,
  parameter int FILL_BITS = 4
) (
  input  logic    cfgClk,
  input  logic    rstN,
  input  logic    din,
  input  logic    active,
  output rxCtrl_t ctrl
);

  localparam int MaxField = (OWN_BITS > LEN_W) ? OWN_BITS : LEN_W;
  localparam int CntW     = $clog2(MaxField + 1);
  localparam int OnesW    = $clog2(MIN_ONES + 1);
  localparam int WordCntW = $clog2(WORD_W);

  rxState_t              state;
  logic [OnesW-1:0]      onesCnt;
  logic [CntW-1:0]       fieldCnt;
  logic [WordCntW-1:0]   wordCnt;
  logic                  runReady;
  logic                  syncExpect;

  assign runReady   = (onesCnt == OnesW'(MIN_ONES));
  assign syncExpect = SyncPattern[~fieldCnt[1:0]];

  always_comb begin
    ctrl        = '0;
    ctrl.fwdBit = 1'b1;
    if (active) begin
      unique case (state)
        ST_HUNT: ctrl.fwdBit = runReady ? din : 1'b1;
        ST_SYNC, ST_FILL: ctrl.fwdBit = din;
        ST_LEN: begin
          ctrl.fwdBit   = din;
          ctrl.shiftLen = 1'b1;
        end
        ST_LOAD: begin
          ctrl.shiftWord = 1'b1;
          ctrl.countBit  = 1'b1;
          ctrl.wordLast  = (wordCnt == WordCntW'(WORD_W - 1));
        end
        ST_PASS: begin
          ctrl.fwdBit   = din;
          ctrl.countBit = 1'b1;
        end
        default: ctrl.fwdBit = 1'b1;
      endcase
    end
  end

  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_HUNT;
      onesCnt  <= '0;
      fieldCnt <= '0;
      wordCnt  <= '0;
    end else if (active) begin
      unique case (state)
        ST_HUNT: begin
          if (din) begin
            if (!runReady) onesCnt <= onesCnt + 1'b1;
          end else if (runReady) begin
            state    <= ST_SYNC;
            fieldCnt <= CntW'(1);
            onesCnt  <= '0;
          end else begin
            onesCnt <= '0;
          end
        end
        ST_SYNC: begin
          if (din == syncExpect) begin
            if (fieldCnt == CntW'(3)) begin
              state    <= ST_LEN;
              fieldCnt <= '0;
            end else begin
              fieldCnt <= fieldCnt + 1'b1;
            end
          end else begin
            state    <= ST_HUNT;
            fieldCnt <= '0;
            onesCnt  <= din ? OnesW'(1) : '0;
          end
        end
        ST_LEN: begin
          if (fieldCnt == CntW'(LEN_W - 1)) begin
            state    <= ST_FILL;
            fieldCnt <= '0;
          end else begin
            fieldCnt <= fieldCnt + 1'b1;
          end
        end
        ST_FILL: begin
          if (fieldCnt == CntW'(FILL_BITS - 1)) begin
            state    <= ST_LOAD;
            fieldCnt <= '0;
          end else begin
            fieldCnt <= fieldCnt + 1'b1;
          end
        end
        ST_LOAD: begin
          wordCnt <= wordCnt + 1'b1;
          if (fieldCnt == CntW'(OWN_BITS - 1)) begin
            state    <= ST_PASS;
            fieldCnt <= '0;
          end else begin
            fieldCnt <= fieldCnt + 1'b1;
          end
        end
        default: state <= state;
      endcase
    end
  end

endmodule

// File: rtl/cfg_rx_path.sv
module cfg_rx_path
  import cfg_serial_rx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LEN_W  = 24
) (
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              din,
  input  rxCtrl_t           ctrl,
  output logic              dout,
  output logic [WORD_W-1:0] wordData,
  output logic              wordStrobe,
  output logic              doneFlag
);

  logic [LEN_W-1:0]  lenReg;
  logic [LEN_W-1:0]  bitTotal;
  logic [WORD_W-2:0] wordShift;
  logic              fwdHold;

  // Rising edge: capture the bit and everything it drives.
  always_ff @(posedge cfgClk or negedge rstN) begin
    if (!rstN) begin
      lenReg     <= '0;
      bitTotal   <= '0;
      wordShift  <= '0;
      wordData   <= '0;
      wordStrobe <= 1'b0;
      doneFlag   <= 1'b0;
      fwdHold    <= 1'b1;
    end else begin
      fwdHold    <= ctrl.fwdBit;
      wordStrobe <= ctrl.wordLast;
      if (ctrl.shiftLen)  lenReg    <= {lenReg[LEN_W-2:0], din};
      if (ctrl.shiftWord) wordShift <= {wordShift[WORD_W-3:0], din};
      if (ctrl.wordLast)  wordData  <= {wordShift, din};
      if (ctrl.countBit && !doneFlag) begin
        bitTotal <= bitTotal + 1'b1;
        if (bitTotal + LEN_W'(1) == lenReg) doneFlag <= 1'b1;
      end
    end
  end

  // Falling edge: half-period re-timing of the forwarded bit.
  always_ff @(negedge cfgClk or negedge rstN) begin
    if (!rstN) dout <= 1'b1;
    else       dout <= fwdHold;
  end

endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_serial_rx_pkg::*;
#(
  parameter int OWN_BITS  = 64,
  parameter int WORD_W    = 32,
  parameter int LEN_W     = 24,
  parameter int MIN_ONES  = 8,
  parameter int FILL_BITS = 4
) (
  input  logic              cfgClk,
  input  logic              rstN,
  input  logic              din,
  input  logic [2:0]        modeSel,
  input  logic              initLine,
  output logic              dout,
  output logic [WORD_W-1:0] wordData,
  output logic              wordStrobe,
  output logic              doneFlag
);

  localparam logic [2:0] SlaveMode = 3'b111;

  rxCtrl_t ctrl;
  logic    active;

  assign active = (modeSel == SlaveMode) && initLine;

  cfg_rx_ctrl #(
    .OWN_BITS (OWN_BITS),
    .WORD_W   (WORD_W),
    .LEN_W    (LEN_W),
    .MIN_ONES (MIN_ONES),
    .FILL_BITS(FILL_BITS)
  ) u_ctrl (
    .cfgClk(cfgClk),
    .rstN  (rstN),
    .din   (din),
    .active(active),
    .ctrl  (ctrl)
  );

  cfg_rx_path #(
    .WORD_W(WORD_W),
    .LEN_W (LEN_W)
  ) u_path (
    .cfgClk    (cfgClk),
    .rstN      (rstN),
    .din       (din),
    .ctrl      (ctrl),
    .dout      (dout),
    .wordData  (wordData),
    .wordStrobe(wordStrobe),
    .doneFlag  (doneFlag)
  );

endmodule

// File: rtl/cfg_serial_rx_chk.sv
module cfg_serial_rx_chk (
  input logic       cfgClk,
  input logic       rstN,
  input logic [2:0] modeSel,
  input logic       initLine,
  input logic       dout,
  input logic       wordStrobe,
  input logic       doneFlag
);

  // R3: with the mode not selecting slave operation, the bit sent is high
  p_idle_high_r3: assert property (@(posedge cfgClk) disable iff (!rstN)
    ($past(modeSel) != 3'b111) |-> dout);

  // R7: the word strobe lasts one cycle
  p_strobe_pulse_r7: assert property (@(posedge cfgClk) disable iff (!rstN)
    wordStrobe |=> !wordStrobe);

  // R9: DONE is sticky
  p_done_sticky_r9: assert property (@(posedge cfgClk) disable iff (!rstN)
    doneFlag |=> doneFlag);

  // R1: a word only completes on a bit taken while active
  p_strobe_active_r1: assert property (@(posedge cfgClk) disable iff (!rstN)
    wordStrobe |-> $past(modeSel == 3'b111 && initLine));

endmodule

bind cfg_serial_rx cfg_serial_rx_chk u_chk (
  .cfgClk    (cfgClk),
  .rstN      (rstN),
  .modeSel   (modeSel),
  .initLine  (initLine),
  .dout      (dout),
  .wordStrobe(wordStrobe),
  .doneFlag  (doneFlag)
);

// File: tb/cfg_serial_rx_tb.sv
`timescale 1ns/1ps
module cfg_serial_rx_tb;

  localparam int OwnBits = 64;

  logic        cfgClk = 1'b0;
  logic        rstN = 1'b0;
  logic        din = 1'b1;
  logic [2:0]  modeSel = 3'b111;
  logic        initLine = 1'b1;
  logic        dout;
  logic [31:0] wordData;
  logic        wordStrobe;
  logic        doneFlag;

  int   total = 0;
  int   bad = 0;
  logic lastDout = 1'b1;
  bit   finished = 0;

  // 10 MHz configuration clock
  always #50 cfgClk = ~cfgClk;

  cfg_serial_rx #(.OWN_BITS(OwnBits)) u_dut (
    .cfgClk    (cfgClk),
    .rstN      (rstN),
    .din       (din),
    .modeSel   (modeSel),
    .initLine  (initLine),
    .dout      (dout),
    .wordData  (wordData),
    .wordStrobe(wordStrobe),
    .doneFlag  (doneFlag)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one bit, then check hold before the falling edge and results after it.
  task automatic sendBit(input logic b, input logic expD, input logic expS,
                         input logic [31:0] expW, input logic expDone, input string req);
    din = b;
    @(posedge cfgClk);
    #20;
    check({req, " R2 dout held until falling edge"}, 32'(dout), 32'(lastDout));
    #40;
    check({req, " dout"}, 32'(dout), 32'(expD));
    check({req, " R7 strobe"}, 32'(wordStrobe), 32'(expS));
    if (expS) check({req, " R7 word"}, wordData, expW);
    check({req, " R9 done"}, 32'(doneFlag), 32'(expDone));
    lastDout = expD;
  endtask

  task automatic doReset();
    @(negedge cfgClk);
    rstN = 1'b0;
    #10;
    check("R10 dout after reset", 32'(dout), 32'd1);
    check("R10 done after reset", 32'(doneFlag), 32'd0);
    check("R10 strobe after reset", 32'(wordStrobe), 32'd0);
    #20;
    modeSel = 3'b111;
    initLine = 1'b1;
    din = 1'b1;
    @(negedge cfgClk);
    #5 rstN = 1'b1;
    lastDout = 1'b1;
  endtask

  task automatic sendHeader(input int nOnes, input logic [23:0] len, input logic fwd, input string req);
    logic [3:0] pat;
    pat = 4'b0010;
    for (int i = 0; i < nOnes; i++) sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R3");
    for (int i = 3; i >= 0; i--) sendBit(pat[i], fwd ? pat[i] : 1'b1, 1'b0, 32'h0, 1'b0, {req, " R5"});
    for (int i = 23; i >= 0; i--) sendBit(len[i], fwd ? len[i] : 1'b1, 1'b0, 32'h0, 1'b0, {req, " R6"});
    for (int i = 0; i < 4; i++) sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, {req, " R6 fill"});
  endtask

  task automatic sendLoad(input logic [31:0] w0, input logic [31:0] w1, input int doneAt);
    for (int i = 0; i < OwnBits; i++) begin
      logic [31:0] w;
      w = (i < 32) ? w0 : w1;
      sendBit(w[31 - (i % 32)], 1'b1, (i == 31) || (i == 63), w,
              (doneAt > 0) && (i + 1 >= doneAt), "R7/R9 own share");
    end
  endtask

  task automatic testBasic();
    logic [11:0] tail;
    tail = 12'b1011_0010_0110;
    doReset();
    sendHeader(10, 24'd72, 1'b1, "R4 basic");
    sendLoad(32'hA5C3_0F96, 32'h3C5A_F00D, 72);
    for (int j = 0; j < 12; j++)
      sendBit(tail[11 - j], tail[11 - j], 1'b0, 32'h0, (64 + j + 1) >= 72, "R8 surplus forwarded");
    doReset();  // R10 from a forwarded 0 on dout
  endtask

  task automatic testSameCycle();
    doReset();
    sendHeader(8, 24'd64, 1'b1, "R4 same-cycle");
    sendLoad(32'h1234_5678, 32'h8000_0001, 64);
    sendBit(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, "R8 after done");
    sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b1, "R8 after done");
    sendBit(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, "R8 after done");
  endtask

  task automatic testRecover();
    logic [3:0] pat;
    pat = 4'b0010;
    doReset();
    for (int i = 0; i < 7; i++) sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R4 short run");
    for (int i = 3; i >= 0; i--) sendBit(pat[i], 1'b1, 1'b0, 32'h0, 1'b0, "R4 short run pattern");
    for (int i = 0; i < 12; i++) sendBit(1'b0, 1'b1, 1'b0, 32'h0, 1'b0, "R3 hunting");
    for (int i = 0; i < 9; i++) sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R3 run");
    sendBit(1'b0, 1'b0, 1'b0, 32'h0, 1'b0, "R5 pattern start forwarded");
    sendBit(1'b1, 1'b1, 1'b0, 32'h0, 1'b0, "R4 mismatch");
    for (int i = 0; i < 6; i++) sendBit(1'b0, 1'b1, 1'b0, 32'h0, 1'b0, "R4 back to hunting");
    sendHeader(8, 24'd32, 1'b1, "R4 recovered");
    sendLoad(32'hDEAD_BEEF, 32'h0F0F_5A5A, 32);
    sendBit(1'b0, 1'b0, 1'b0, 32'h0, 1'b1, "R8 recovered forward");
  endtask

  task automatic testInhibit();
    doReset();
    initLine = 1'b0;
    sendHeader(10, 24'd32, 1'b0, "R1 init low");
    for (int i = 0; i < 32; i++) sendBit(1'b0, 1'b1, 1'b0, 32'h0, 1'b0, "R1 init low data");
    initLine = 1'b1;
    for (int i = 0; i < 40; i++) sendBit(i[0], 1'b1, 1'b0, 32'h0, 1'b0, "R1 no header kept");
    modeSel = 3'b110;
    sendHeader(10, 24'd32, 1'b0, "R3 mode 110");
    for (int i = 0; i < 8; i++) sendBit(1'b0, 1'b1, 1'b0, 32'h0, 1'b0, "R3 mode 110 data");
    modeSel = 3'b011;
    sendHeader(9, 24'd16, 1'b0, "R3 mode 011");
    modeSel = 3'b111;
    sendHeader(8, 24'd32, 1'b1, "R1 header after enable");
    sendLoad(32'hCAFE_0001, 32'h7654_3210, 32);
  endtask

  initial begin
    #4_000_000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    doReset();
    testBasic();
    testSameCycle();
    testRecover();
    testInhibit();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule